// File: doc/BRIEF.md
# Checksummed Configuration Store

This block keeps 32 bytes of node configuration in registers that survive a soft reset. Ten bytes hold the node settings and twenty-one are free for the host. The last byte is an XOR check value that the block updates on every write. The settings are decoded onto plain output pins: node ID, radio channel, transmit power, sleep length, wake timeout, serial rate code with its bit rate, wake pin mask and feature flags.

Each soft reset starts an integrity scan of bytes 0 to 30 against the stored check byte. A mismatch reloads the settings bytes with their defaults and rewrites the check byte. A forced-default input that is held during reset does the same. The user bytes survive both kinds of restore. A separate power-on reset models blank storage: it clears every byte and sets the check byte to 0xFF, so the first scan always fails and loads the defaults.

Host accesses use a valid/ready request stream and a valid/ready response stream. A request is accepted on a cycle where both `req_valid` and `req_ready` are high. Every accepted request produces exactly one response, and responses come back in request order. While a response waits unaccepted, `req_ready` stays low, so the design never holds more than one result. While `busy` is high, no request is accepted.

Top module: `cfg_store`

## Requirements
- R1: When `por_n` is low, every byte is cleared to 0x00 except byte 31, which is set to 0xFF. The first check that follows therefore fails and loads the settings defaults: bytes 0/1 = 0x00/0x02, byte 2 = 7, byte 3 = 15, bytes 4/5 = 0x00/0x01, byte 6 = 2, byte 7 = 2, byte 8 = 0x80 and byte 9 = 0.
- R2: `busy` is high while `rst_n` is low and stays high after release until the check (and any restore) is done, within 45 cycles. `req_ready` is low whenever `busy` is high.
- R3: A read of address 0–31 returns that byte with `rsp_err`=0. Bytes 0/1 hold the ID (high byte first), 2 the channel, 3 the power, 4/5 the sleep length (high byte first), 6 the wake timeout, 7 the rate code, 8 the pin mask, 9 the feature flags, 10–30 the user area and 31 the check byte.
- R4: An accepted write to address 0–30 stores the byte and, in the same clock edge, makes byte 31 equal to the XOR of bytes 0–30. Its response has `rsp_data`=0 and `rsp_err`=0.
- R5: A write to address 31 is rejected with `rsp_err`=1 and changes no byte.
- R6: A write of a value above 15 to byte 2 or byte 3, or of a value above 7 to byte 7, is rejected with `rsp_err`=1 and changes no byte.
- R7: A soft reset with a matching check byte and `force_dflt` low leaves all 32 bytes unchanged.
- R8: If `force_dflt` is high while `rst_n` is low, the settings are reloaded with the R1 defaults and byte 31 is rewritten. Bytes 10–30 keep their values.
- R9: The decoded outputs follow the stored bytes. Rate codes 0–7 map to 2400, 4800, 9600, 14400, 19200, 38400, 128000 and 250000 bit/s.
- R10: Responses come back one per accepted request, in order. While `rsp_valid` is high and `rsp_ready` is low, the response is held stable and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; blanks the storage |
| rst_n | input | 1 | Soft reset, active low; storage kept |
| force_dflt | input | 1 | Sampled during soft reset; forces a settings restore |
| busy | output | 1 | Check or restore in progress |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes response |
| rsp_data | output | 8 | Read data (0 for writes) |
| rsp_err | output | 1 | Write rejected |
| own_id | output | 16 | Node ID |
| channel | output | 4 | Radio channel |
| tx_power | output | 4 | Transmit power step |
| sleep_len | output | 16 | Sleep length |
| wake_tmo | output | 8 | Wake timeout |
| baud_code | output | 3 | Serial rate code |
| baud_rate | output | 18 | Decoded bit rate |
| wake_mask | output | 8 | Wake pin mask |
| features | output | 8 | Feature flags |

## Verification
The bench builds the block with its default parameters: 32 bytes with a 10-byte settings region. With these values the check byte sits at address 31, reachable by a 5-bit address, so the rejected-write path and the full 31-byte scan are both exercised. The bench restores the settings once through the power-on mismatch and once through the forced input. This shows both restore triggers, and the forced restore is done over a non-zero user area, so its preservation can be observed.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

  typedef enum logic [1:0] {BT_SCAN, BT_FILL, BT_SEAL, BT_READY} boot_st_t;

  localparam int ADR_ID_HI  = 0;
  localparam int ADR_ID_LO  = 1;
  localparam int ADR_CHAN   = 2;
  localparam int ADR_PWR    = 3;
  localparam int ADR_SLP_HI = 4;
  localparam int ADR_SLP_LO = 5;
  localparam int ADR_WAKE   = 6;
  localparam int ADR_BAUD   = 7;
  localparam int ADR_MASK   = 8;
  localparam int ADR_FEAT   = 9;

  localparam logic [7:0] CHAN_MAX = 8'd15;
  localparam logic [7:0] PWR_MAX  = 8'd15;
  localparam logic [7:0] BAUD_MAX = 8'd7;

  function automatic logic [7:0] dflt_byte(input int idx);
    case (idx)
      ADR_ID_LO:  return 8'd2;
      ADR_CHAN:   return 8'd7;
      ADR_PWR:    return 8'd15;
      ADR_SLP_LO: return 8'd1;
      ADR_WAKE:   return 8'd2;
      ADR_BAUD:   return 8'd2;
      ADR_MASK:   return 8'h80;
      default:    return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] dflt_xor(input int n);
    logic [7:0] x;
    x = 8'd0;
    for (int i = 0; i < n; i++) x = x ^ dflt_byte(i);
    return x;
  endfunction

  function automatic logic [17:0] baud_of(input logic [2:0] code);
    case (code)
      3'd0: return 18'd2400;
      3'd1: return 18'd4800;
      3'd2: return 18'd9600;
      3'd3: return 18'd14400;
      3'd4: return 18'd19200;
      3'd5: return 18'd38400;
      3'd6: return 18'd128000;
      default: return 18'd250000;
    endcase
  endfunction

endpackage

// File: rtl/cfg_bytes.sv
module cfg_bytes #(
  parameter int NB = 32,
  localparam int AW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [7:0]      wdata,
  input  logic            chk_we,
  input  logic [7:0]      chk_wdata,
  output logic [NB*8-1:0] bytes_flat
);
  localparam int CHK = NB - 1;

  logic [7:0] old_byte;
  assign old_byte = bytes_flat[{waddr, 3'b000} +: 8];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] r;
    if (g == CHK) begin : g_chk
      // Check byte: written directly by the restore seal, otherwise
      // updated incrementally so it stays the XOR of all other bytes.
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      r <= 8'hFF;
        else if (chk_we) r <= chk_wdata;
        else if (we)     r <= r ^ old_byte ^ wdata;
      end
    end else begin : g_dat
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                      r <= 8'h00;
        else if (we && waddr == AW'(g))  r <= wdata;
      end
    end
    assign bytes_flat[g*8 +: 8] = r;
  end

endmodule

// File: rtl/cfg_boot.sv
module cfg_boot
  import cfg_store_pkg::*;
#(
  parameter int NB   = 32,
  parameter int NSET = 10,
  localparam int AW  = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_dflt,
  input  logic [NB*8-1:0] bytes_flat,
  output logic            busy,
  output logic            fix_we,
  output logic [AW-1:0]   fix_addr,
  output logic [7:0]      fix_data,
  output logic            seal_we,
  output logic [7:0]      seal_data
);
  localparam int CHK  = NB - 1;
  localparam int LAST = NB - 2;
  localparam logic [7:0] DFLT_X = dflt_xor(NSET);

  boot_st_t      st;
  logic [AW-1:0] idx;
  logic [7:0]    acc, usr, cur, chk;
  logic          force_q;

  assign cur = bytes_flat[{idx, 3'b000} +: 8];
  assign chk = bytes_flat[CHK*8 +: 8];

  // Forced restore request is captured while soft reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) force_q <= force_dflt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= BT_SCAN;
      idx <= '0;
      acc <= '0;
      usr <= '0;
    end else begin
      case (st)
        BT_SCAN: begin
          acc <= acc ^ cur;
          if (idx >= AW'(NSET)) usr <= usr ^ cur;
          if (idx == AW'(LAST)) begin
            idx <= '0;
            if (((acc ^ cur) != chk) || force_q) st <= BT_FILL;
            else                                 st <= BT_READY;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        BT_FILL: begin
          if (idx == AW'(NSET - 1)) st <= BT_SEAL;
          idx <= idx + 1'b1;
        end
        BT_SEAL:  st <= BT_READY;
        default:  st <= BT_READY;
      endcase
    end
  end

  assign busy      = (st != BT_READY);
  assign fix_we    = (st == BT_FILL);
  assign fix_addr  = idx;
  assign fix_data  = dflt_byte(int'(idx));
  assign seal_we   = (st == BT_SEAL);
  assign seal_data = DFLT_X ^ usr;

endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_store_pkg::*;
#(
  parameter int NB  = 32,
  localparam int AW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [7:0]      req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [7:0]      rsp_data,
  output logic            rsp_err,
  input  logic [NB*8-1:0] bytes_flat,
  output logic            host_we
);
  localparam int CHK = NB - 1;

  logic fire, bad;

  assign req_ready = !busy && (!rsp_valid || rsp_ready);
  assign fire      = req_valid && req_ready;

  always_comb begin
    bad = 1'b0;
    if (req_addr == AW'(CHK))                              bad = 1'b1;
    if (req_addr == AW'(ADR_CHAN) && req_wdata > CHAN_MAX) bad = 1'b1;
    if (req_addr == AW'(ADR_PWR)  && req_wdata > PWR_MAX)  bad = 1'b1;
    if (req_addr == AW'(ADR_BAUD) && req_wdata > BAUD_MAX) bad = 1'b1;
  end

  assign host_we = fire && req_write && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_write ? 8'h00 : bytes_flat[{req_addr, 3'b000} +: 8];
      rsp_err   <= req_write && bad;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import cfg_store_pkg::*;
#(
  parameter int NB = 32
) (
  input  logic [NB*8-1:0] bytes_flat,
  output logic [15:0]     own_id,
  output logic [3:0]      channel,
  output logic [3:0]      tx_power,
  output logic [15:0]     sleep_len,
  output logic [7:0]      wake_tmo,
  output logic [2:0]      baud_code,
  output logic [17:0]     baud_rate,
  output logic [7:0]      wake_mask,
  output logic [7:0]      features
);
  function automatic logic [7:0] at(input int a);
    return bytes_flat[a*8 +: 8];
  endfunction

  logic [7:0] b_chan, b_pwr, b_baud;
  assign b_chan = at(ADR_CHAN);
  assign b_pwr  = at(ADR_PWR);
  assign b_baud = at(ADR_BAUD);

  assign own_id    = {at(ADR_ID_HI), at(ADR_ID_LO)};
  assign channel   = b_chan[3:0];
  assign tx_power  = b_pwr[3:0];
  assign sleep_len = {at(ADR_SLP_HI), at(ADR_SLP_LO)};
  assign wake_tmo  = at(ADR_WAKE);
  assign baud_code = b_baud[2:0];
  assign baud_rate = baud_of(b_baud[2:0]);
  assign wake_mask = at(ADR_MASK);
  assign features  = at(ADR_FEAT);

  logic unused_hi;
  assign unused_hi = ^{b_chan[7:4], b_pwr[7:4], b_baud[7:3]};

endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int NUM_BYTES = 32,
  parameter int SET_BYTES = 10,
  localparam int AW = $clog2(NUM_BYTES)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          force_dflt,
  output logic          busy,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_data,
  output logic          rsp_err,
  output logic [15:0]   own_id,
  output logic [3:0]    channel,
  output logic [3:0]    tx_power,
  output logic [15:0]   sleep_len,
  output logic [7:0]    wake_tmo,
  output logic [2:0]    baud_code,
  output logic [17:0]   baud_rate,
  output logic [7:0]    wake_mask,
  output logic [7:0]    features
);
  logic [NUM_BYTES*8-1:0] bytes_flat;
  logic                   host_we, fix_we, seal_we, we;
  logic [AW-1:0]          fix_addr, waddr;
  logic [7:0]             fix_data, seal_data, wdata;

  // Host and restore writes never overlap: the host side is gated by busy.
  assign we    = host_we | fix_we;
  assign waddr = fix_we ? fix_addr : req_addr;
  assign wdata = fix_we ? fix_data : req_wdata;

  cfg_bytes #(.NB(NUM_BYTES)) u_bytes (
    .clk(clk), .por_n(por_n), .we(we), .waddr(waddr), .wdata(wdata),
    .chk_we(seal_we), .chk_wdata(seal_data), .bytes_flat(bytes_flat)
  );

  cfg_boot #(.NB(NUM_BYTES), .NSET(SET_BYTES)) u_boot (
    .clk(clk), .rst_n(rst_n), .force_dflt(force_dflt), .bytes_flat(bytes_flat),
    .busy(busy), .fix_we(fix_we), .fix_addr(fix_addr), .fix_data(fix_data),
    .seal_we(seal_we), .seal_data(seal_data)
  );

  cfg_port #(.NB(NUM_BYTES)) u_port (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .bytes_flat(bytes_flat), .host_we(host_we)
  );

  cfg_decode #(.NB(NUM_BYTES)) u_dec (
    .bytes_flat(bytes_flat), .own_id(own_id), .channel(channel),
    .tx_power(tx_power), .sleep_len(sleep_len), .wake_tmo(wake_tmo),
    .baud_code(baud_code), .baud_rate(baud_rate), .wake_mask(wake_mask),
    .features(features)
  );

endmodule

// File: rtl/cfg_store_chk.sv
module cfg_store_chk #(
  parameter int NB   = 32,
  parameter int NSET = 10,
  localparam int AW  = $clog2(NB)
) (
  input logic            clk,
  input logic            por_n,
  input logic            rst_n,
  input logic            busy,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [AW-1:0]   req_addr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [7:0]      rsp_data,
  input logic [NB*8-1:0] bytes_flat
);
  logic [7:0] xor_lo;
  logic [(NB-1-NSET)*8-1:0] user_flat;

  always_comb begin
    xor_lo = 8'd0;
    for (int i = 0; i < NB - 1; i++) xor_lo = xor_lo ^ bytes_flat[i*8 +: 8];
  end
  assign user_flat = bytes_flat[(NB-1)*8-1 : NSET*8];

  // R2
  busy_gate_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy |-> !req_ready);

  // R4
  chk_sum_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !busy |-> (xor_lo == bytes_flat[(NB-1)*8 +: 8]));

  // R5
  rej_chk_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_valid && req_ready && req_write && req_addr == AW'(NB-1))
      |=> $stable(bytes_flat));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  user_keep_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy |=> $stable(user_flat));

endmodule

bind cfg_store cfg_store_chk #(.NB(NUM_BYTES), .NSET(SET_BYTES)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .busy(busy),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .bytes_flat(bytes_flat)
);

// File: tb/cfg_store_bench.sv
`timescale 1ns/1ps
module cfg_store_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n, rst_n, force_dflt, busy;
  logic req_valid, req_ready, req_write, rsp_valid, rsp_ready, rsp_err;
  logic [4:0] req_addr;
  logic [7:0] req_wdata, rsp_data, wake_tmo, wake_mask, features;
  logic [15:0] own_id, sleep_len;
  logic [3:0] channel, tx_power;
  logic [2:0] baud_code;
  logic [17:0] baud_rate;

  cfg_store u_cfg_store (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .force_dflt(force_dflt), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .own_id(own_id), .channel(channel), .tx_power(tx_power), .sleep_len(sleep_len),
    .wake_tmo(wake_tmo), .baud_code(baud_code), .baud_rate(baud_rate),
    .wake_mask(wake_mask), .features(features)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [32];
  logic [7:0] dflt [10] = '{8'h00, 8'h02, 8'h07, 8'h0F, 8'h00, 8'h01, 8'h02, 8'h02, 8'h80, 8'h00};
  logic [7:0] q_data [$];
  logic       q_err  [$];
  string      q_tag  [$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void reseal();
    logic [7:0] x = 8'h00;
    for (int i = 0; i < 31; i++) x ^= model[i];
    model[31] = x;
  endfunction

  function automatic void load_dflt();
    for (int i = 0; i < 10; i++) model[i] = dflt[i];
    reseal();
  endfunction

  // Driver: compute the expected response from the requirements, queue it, drive it.
  task automatic do_req(input bit wr, input logic [4:0] a, input logic [7:0] d, input string tag);
    bit bad;
    bad = wr && ((a == 5'd31) || ((a == 5'd2 || a == 5'd3) && d > 8'd15) || (a == 5'd7 && d > 8'd7));
    q_tag.push_back(tag);
    q_err.push_back(bad);
    q_data.push_back(wr ? 8'h00 : model[a]);
    if (wr && !bad) begin model[a] = d; reseal(); end
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (q_data.size() != 0 && n < 200) begin @(negedge clk); n++; end
    check("R10 drain", q_data.size(), 0);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
    check({tag, " R2 restore length ok"}, (n <= 45), 1);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 32; i++) do_req(1'b0, 5'(i), 8'h00, tag);
    drain();
  endtask

  task automatic check_dflt_outs(input string tag);
    check({tag, " R1 id"},    own_id, 16'd2);
    check({tag, " R1 chan"},  channel, 4'd7);
    check({tag, " R1 pwr"},   tx_power, 4'd15);
    check({tag, " R1 sleep"}, sleep_len, 16'd1);
    check({tag, " R1 wake"},  wake_tmo, 8'd2);
    check({tag, " R9 baud"},  baud_rate, 18'd9600);
    check({tag, " R1 mask"},  wake_mask, 8'h80);
    check({tag, " R1 feat"},  features, 8'h00);
  endtask

  // Monitor: pop expected items as responses are handed over.
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rsp_valid && rsp_ready) begin
        if (q_data.size() == 0) check("R10 unexpected response", 1, 0);
        else begin
          string t = q_tag.pop_front();
          check({t, " data"}, rsp_data, q_data.pop_front());
          check({t, " err"},  rsp_err,  q_err.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 0; force_dflt = 0; rsp_ready = 1;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    for (int i = 0; i < 31; i++) model[i] = 8'h00;
    load_dflt();
    repeat (4) @(negedge clk);
    por_n = 1;
    repeat (2) @(negedge clk);
    check("R2 busy in reset", busy, 1);
    rst_n = 1;
    #1;
    check("R2 busy after release", busy, 1);
    check("R2 no ready while busy", req_ready, 0);
    wait_ready("por");
    check_dflt_outs("por");
    read_all("R1 R3 power-on contents");

    // R4: writes to user area and settings, each reseals the check byte
    for (int i = 10; i < 31; i++) do_req(1'b1, 5'(i), 8'(i * 7 + 3), "R4 user write");
    do_req(1'b1, 5'd0, 8'h12, "R4 id hi");
    do_req(1'b1, 5'd1, 8'h34, "R4 id lo");
    do_req(1'b1, 5'd2, 8'd11, "R4 chan");
    do_req(1'b1, 5'd3, 8'd15, "R4 pwr edge");
    do_req(1'b1, 5'd5, 8'h0C, "R4 sleep lo");
    do_req(1'b1, 5'd7, 8'd6, "R4 baud");
    do_req(1'b0, 5'd31, 8'h00, "R4 check byte");
    drain();
    check("R9 id", own_id, 16'h1234);
    check("R9 chan", channel, 4'd11);
    check("R9 pwr", tx_power, 4'd15);
    check("R9 sleep", sleep_len, 16'h000C);
    check("R9 code", baud_code, 3'd6);
    check("R9 rate", baud_rate, 18'd128000);

    // R5 / R6: rejected writes, contents read back unchanged
    do_req(1'b1, 5'd31, 8'h5A, "R5 write chk");
    do_req(1'b1, 5'd2, 8'd16, "R6 chan 16");
    do_req(1'b1, 5'd3, 8'hFF, "R6 pwr FF");
    do_req(1'b1, 5'd7, 8'd8, "R6 baud 8");
    read_all("R5 R6 after rejects");
    check("R6 chan out", channel, 4'd11);

    // R10: back-pressure on the response stream
    fork
      begin
        for (int i = 0; i < 8; i++) do_req(1'b0, 5'(i * 4 + 1), 8'h00, "R10 bp read");
      end
      begin
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          rsp_ready = (k % 3 == 0);
          #1;
          if (rsp_valid && !rsp_ready) check("R10 ready low while held", req_ready, 0);
        end
        @(negedge clk);
        rsp_ready = 1'b1;
      end
    join
    drain();

    // R7: soft reset keeps everything
    do_req(1'b1, 5'd7, 8'd7, "R4 baud 7");
    drain();
    check("R9 rate 7", baud_rate, 18'd250000);
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    #1; check("R2 busy soft", busy, 1);
    wait_ready("soft");
    check("R7 id kept", own_id, 16'h1234);
    read_all("R7 soft reset contents");

    // R8: forced restore keeps user bytes
    @(negedge clk); rst_n = 0; force_dflt = 1;
    repeat (3) @(negedge clk); rst_n = 1;
    @(negedge clk); force_dflt = 0;
    load_dflt();
    wait_ready("force");
    check_dflt_outs("R8 force");
    read_all("R8 forced contents");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule